// File: doc/BRIEF.md
# Protected Shadow Register Commit Unit

This block is the bus-facing register front end of a slow, always-on timekeeping domain. Software writes land in shadow copies of the time and alarm fields. They reach the active copies, which drive the time and alarm core, only when software writes the commit register. A busy bit stays set while the transfer is in flight. The crossing into the slow domain is modelled as a fixed number of cycles. When that delay ends, the active values update and a one-cycle apply pulse tells the core that new data is present.

Two gates protect the time and alarm fields. First, a pair of power-valid key registers must hold fixed magic words. The keys themselves can only be written once both configuration registers have been committed with their required values. Second, a two-word unlock sequence must be written to the protection register, with a commit after each word. A wrong word, or a write to any other register between the two words, returns the sequence to the locked state. The control register accepts writes only when bits 15:8 carry 0x43. Through it, software can reload the shadows from the active values or wipe the power keys.

After reset, and after the keys are wiped, the stored time is flagged invalid. The flag clears when a commit carries a newly written time field.

Top module: `prot_shadow_commit`

## Requirements
- R1: After reset the control register (word address 0x00) reads 0x1. Bit 0 (time invalid) is set and bit 6 (busy), bit 2 (unlocked) and bit 1 (keys valid) are clear. Every time field reads 0 and `apply` is low.
- R2: When idle, writing a word with bit 0 set to the commit register (word 0x1E) sets busy for exactly COMMIT_CYC cycles starting after the write edge. On the edge where busy falls, the active values take the shadow values, and `apply` is high for the following single cycle.
- R3: Every register write made while busy is ignored, including a second commit, which neither restarts nor lengthens the transfer.
- R4: Reads are registered and return data one cycle after `rd_en`. Time fields (word 0x05 upward) and alarm fields (word 0x0C upward) read their active values, so a shadow write is not visible until it is committed.
- R5: Time and alarm shadow writes are ignored unless the unit is unlocked and the keys are valid.
- R6: Committing 0x9136 and then committing 0x586A to the protection register (word 0x1C) sets control bit 2 (unlocked).
- R7: A committed protection word that breaks the sequence returns the unit to locked. So does any write other than to the protection or commit register while the first word is held. Any wrong word committed while unlocked also relocks the unit.
- R8: A write to the control register whose bits 15:8 are not 0x43 has no effect.
- R9: Control bit 5 (with the key byte) copies the active time and alarm values back into the shadows, discarding pending writes.
- R10: Control bit 4 (with the key byte) zeroes both key registers. Keys-valid then drops and time-invalid is set.
- R11: Key registers (words 0x13 and 0x14) accept writes only once the configuration registers (words 0x17 and 0x18) hold active values 0x4848 and 0x0048. Keys are valid when they hold 0xA357 and 0x67D2.
- R12: Time-invalid clears on a commit that carries at least one accepted time-field write, and on no other commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| apply | output | 1 | One-cycle pulse after a commit lands |
| time_out | output | NFIELD*FIELD_W | Active time fields toward the core |
| alarm_out | output | NFIELD*FIELD_W | Active alarm fields toward the core |
| time_valid | output | 1 | Stored time is valid |

## Verification
The hardest situation to reach from the ports is the half-unlocked state with an interleaved write, because it only exists between two separate commit transfers. The stimulus gets there in three ways. It commits the first unlock word, then writes a time field before the second word. It commits a wrong first word. It issues a second commit and a shadow write while a transfer is still busy. Directed steps walk the configuration, key and unlock order. A seeded random phase then mixes shadow writes, reloads, commits and reads against a bench model of the shadow and active copies.

// File: rtl/psc_pkg.sv
package psc_pkg;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [AW-1:0] A_CTRL   = 5'h00;
  localparam logic [AW-1:0] A_TIME0  = 5'h05;
  localparam logic [AW-1:0] A_ALRM0  = 5'h0C;
  localparam logic [AW-1:0] A_KEYA   = 5'h13;
  localparam logic [AW-1:0] A_KEYB   = 5'h14;
  localparam logic [AW-1:0] A_CFGA   = 5'h17;
  localparam logic [AW-1:0] A_CFGB   = 5'h18;
  localparam logic [AW-1:0] A_PROT   = 5'h1C;
  localparam logic [AW-1:0] A_COMMIT = 5'h1E;

  localparam logic [15:0] UNLK_W1 = 16'h9136;
  localparam logic [15:0] UNLK_W2 = 16'h586A;
  localparam logic [15:0] KEYA_V  = 16'hA357;
  localparam logic [15:0] KEYB_V  = 16'h67D2;
  localparam logic [15:0] CFGA_V  = 16'h4848;
  localparam logic [15:0] CFGB_V  = 16'h0048;
  localparam logic [7:0]  CTRL_KEY = 8'h43;

  localparam int B_BUSY   = 6;
  localparam int B_RELOAD = 5;
  localparam int B_CLRKEY = 4;
  localparam int B_UNLK   = 2;
  localparam int B_KOK    = 1;
  localparam int B_TINV   = 0;

  typedef enum logic [1:0] {LK_CLOSED, LK_HALF, LK_OPEN} lk_state_t;
endpackage

// File: rtl/psc_commit_timer.sv
module psc_commit_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fire,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt;

  assign fire = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(CYC - 1);
      end
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy); // R2
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2
endmodule

// File: rtl/psc_shadow_bank.sv
module psc_shadow_bank #(
  parameter int N = 6,
  parameter int W = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  input  logic          reload,
  input  logic          clr,
  input  logic          fire,
  output logic [N*W-1:0] act
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [W-1:0] sh;
    logic [W-1:0] ac;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        sh <= '0;
        ac <= '0;
      end else begin
        if (reload) sh <= ac;
        else if (we && idx == IW'(g)) sh <= wdata;
        if (fire) ac <= sh;
      end
    end
    assign act[g*W +: W] = ac;
  end

  AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!fire && !clr) |=> $stable(act)); // R4
endmodule

// File: rtl/psc_unlock.sv
module psc_unlock
  import psc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_we,
  input  logic [15:0] wdata,
  input  logic        other_we,
  input  logic        fire,
  output logic        unlocked
);
  lk_state_t   st;
  logic [15:0] word;
  logic        pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= LK_CLOSED;
      word <= '0;
      pend <= 1'b0;
    end else begin
      if (prot_we) begin
        word <= wdata;
        pend <= 1'b1;
      end
      if (other_we && st == LK_HALF) st <= LK_CLOSED;
      if (fire && pend) begin
        pend <= 1'b0;
        if (word == UNLK_W1) st <= LK_HALF;
        else if (word == UNLK_W2 && st == LK_HALF) st <= LK_OPEN;
        else st <= LK_CLOSED;
      end
    end
  end

  assign unlocked = (st == LK_OPEN);

  AST_OPEN_FROM_HALF: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(st == LK_HALF)); // R6
  AST_HALF_BROKEN: assert property (@(posedge clk) disable iff (rst)
    (st == LK_HALF && other_we) |=> (st == LK_CLOSED)); // R7
endmodule

// File: rtl/prot_shadow_commit.sv
module prot_shadow_commit
  import psc_pkg::*;
#(
  parameter int NFIELD     = 6,
  parameter int FIELD_W    = 8,
  parameter int COMMIT_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [4:0]                addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic                      apply,
  output logic [NFIELD*FIELD_W-1:0] time_out,
  output logic [NFIELD*FIELD_W-1:0] alarm_out,
  output logic                      time_valid
);
  localparam int TIW = (NFIELD > 1) ? $clog2(NFIELD) : 1;

  logic busy, fire, done, unlocked, keys_ok, cfg_ok;
  logic wr_ok, hit_time, hit_alrm, time_we, alarm_we, key_we, cfg_we;
  logic ctrl_we, reload, clrkey, start, prot_we, other_we;
  logic [TIW-1:0] tidx, aidx;
  logic [NFIELD*FIELD_W-1:0] time_act, alarm_act;
  logic [31:0] key_act, cfg_act;
  logic time_inv, time_pend;
  logic [FIELD_W-1:0] tfield, afield;
  logic [31:0] rd_word;
  logic unused_hi;

  assign unused_hi = ^wdata[31:16];

  // decode
  assign wr_ok    = wr_en && !busy;
  assign hit_time = (int'(addr) >= int'(A_TIME0)) && (int'(addr) < int'(A_TIME0) + NFIELD);
  assign hit_alrm = (int'(addr) >= int'(A_ALRM0)) && (int'(addr) < int'(A_ALRM0) + NFIELD);
  assign tidx     = TIW'(addr - A_TIME0);
  assign aidx     = TIW'(addr - A_ALRM0);
  assign time_we  = wr_ok && hit_time && unlocked && keys_ok;
  assign alarm_we = wr_ok && hit_alrm && unlocked && keys_ok;
  assign key_we   = wr_ok && cfg_ok && (addr == A_KEYA || addr == A_KEYB);
  assign cfg_we   = wr_ok && (addr == A_CFGA || addr == A_CFGB);
  assign ctrl_we  = wr_ok && (addr == A_CTRL) && (wdata[15:8] == CTRL_KEY);
  assign reload   = ctrl_we && wdata[B_RELOAD];
  assign clrkey   = ctrl_we && wdata[B_CLRKEY];
  assign start    = wr_ok && (addr == A_COMMIT) && wdata[0];
  assign prot_we  = wr_ok && (addr == A_PROT);
  assign other_we = wr_ok && (addr != A_PROT) && (addr != A_COMMIT);

  assign keys_ok = (key_act[15:0] == KEYA_V) && (key_act[31:16] == KEYB_V);
  assign cfg_ok  = (cfg_act[15:0] == CFGA_V) && (cfg_act[31:16] == CFGB_V);

  psc_commit_timer #(.CYC(COMMIT_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .fire(fire), .done(done)
  );

  psc_unlock u_unlock (
    .clk(clk), .rst(rst), .prot_we(prot_we), .wdata(wdata[15:0]),
    .other_we(other_we), .fire(fire), .unlocked(unlocked)
  );

  psc_shadow_bank #(.N(NFIELD), .W(FIELD_W)) u_time (
    .clk(clk), .rst(rst), .we(time_we), .idx(tidx), .wdata(wdata[FIELD_W-1:0]),
    .reload(reload), .clr(1'b0), .fire(fire), .act(time_act)
  );

  psc_shadow_bank #(.N(NFIELD), .W(FIELD_W)) u_alarm (
    .clk(clk), .rst(rst), .we(alarm_we), .idx(aidx), .wdata(wdata[FIELD_W-1:0]),
    .reload(reload), .clr(1'b0), .fire(fire), .act(alarm_act)
  );

  psc_shadow_bank #(.N(2), .W(16)) u_keys (
    .clk(clk), .rst(rst), .we(key_we), .idx(addr == A_KEYB), .wdata(wdata[15:0]),
    .reload(1'b0), .clr(clrkey), .fire(fire), .act(key_act)
  );

  psc_shadow_bank #(.N(2), .W(16)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(addr == A_CFGB), .wdata(wdata[15:0]),
    .reload(1'b0), .clr(1'b0), .fire(fire), .act(cfg_act)
  );

  // time validity tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      time_inv  <= 1'b1;
      time_pend <= 1'b0;
    end else begin
      if (time_we) time_pend <= 1'b1;
      else if (fire || reload) time_pend <= 1'b0;
      if (clrkey) time_inv <= 1'b1;
      else if (fire && time_pend) time_inv <= 1'b0;
    end
  end

  // read path
  always_comb begin
    tfield = '0;
    afield = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (tidx == TIW'(i)) tfield = time_act[i*FIELD_W +: FIELD_W];
      if (aidx == TIW'(i)) afield = alarm_act[i*FIELD_W +: FIELD_W];
    end
    rd_word = '0;
    if (addr == A_CTRL) begin
      rd_word[B_BUSY] = busy;
      rd_word[B_UNLK] = unlocked;
      rd_word[B_KOK]  = keys_ok;
      rd_word[B_TINV] = time_inv;
    end else if (hit_time) begin
      rd_word[FIELD_W-1:0] = tfield;
    end else if (hit_alrm) begin
      rd_word[FIELD_W-1:0] = afield;
    end else if (addr == A_KEYA) begin
      rd_word[15:0] = key_act[15:0];
    end else if (addr == A_KEYB) begin
      rd_word[15:0] = key_act[31:16];
    end else if (addr == A_CFGA) begin
      rd_word[15:0] = cfg_act[15:0];
    end else if (addr == A_CFGB) begin
      rd_word[15:0] = cfg_act[31:16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_word;
  end

  assign apply      = done;
  assign time_out   = time_act;
  assign alarm_out  = alarm_act;
  assign time_valid = !time_inv;

  AST_KEYS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clrkey |=> !keys_ok); // R10
  AST_BAD_KEY_BYTE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy && addr == A_CTRL && wdata[15:8] != CTRL_KEY) |=> ($stable(time_inv) && $stable(key_act))); // R8
  AST_LOCKED_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && !time_pend) |=> !time_pend); // R5
endmodule

// File: tb/test_prot_shadow_commit.sv
module test_prot_shadow_commit;
  localparam int CYC = 4;
  localparam int NF  = 6;
  localparam logic [4:0] CTRL = 5'h00, COMMIT = 5'h1E, PROT = 5'h1C;
  localparam logic [4:0] KA = 5'h13, KB = 5'h14, CA = 5'h17, CB = 5'h18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic apply, time_valid;
  logic [NF*8-1:0] time_out, alarm_out;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m_sh [0:11];
  logic [7:0] m_act [0:11];
  bit m_open = 1'b0;

  always #2.5 clk = ~clk;

  prot_shadow_commit #(.NFIELD(NF), .FIELD_W(8), .COMMIT_CYC(CYC)) i_prot_shadow_commit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .apply(apply), .time_out(time_out), .alarm_out(alarm_out),
    .time_valid(time_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [4:0] field_addr(input int i);
    return (i < NF) ? 5'(5 + i) : 5'(12 + i - NF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_wr(input int i, input logic [31:0] v);
    wr(field_addr(i), v);
    if (m_open) m_sh[i] = v[7:0];
  endtask

  task automatic t_commit();
    wr(COMMIT, 32'h1);
    repeat (CYC + 1) @(negedge clk);
    for (int i = 0; i < 12; i++) m_act[i] = m_sh[i];
  endtask

  task automatic t_reload();
    wr(CTRL, 32'h4320);
    for (int i = 0; i < 12; i++) m_sh[i] = m_act[i];
  endtask

  task automatic chk_field(input string tag, input int i);
    logic [31:0] d;
    rd(field_addr(i), d);
    chk(tag, d, {24'h0, m_act[i]});
  endtask

  task automatic chk_ctrl(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(CTRL, d);
    chk(tag, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 12; i++) begin m_sh[i] = '0; m_act[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk_ctrl("R1 ctrl after reset", 32'h1);
    chk("R1 apply low", {31'h0, apply}, 32'h0);
    chk_field("R1 time field zero", 0);

    // R5 locked and no keys
    t_wr(0, 32'h12); t_commit();
    chk_field("R5 locked write ignored", 0);

    // R11 keys before config are ignored
    wr(KA, 32'hA357); wr(KB, 32'h67D2); t_commit();
    chk_ctrl("R11 keys ignored before config", 32'h1);
    rd(KA, d); chk("R11 key reg stays zero", d, 32'h0);

    wr(CA, 32'h4848); wr(CB, 32'h0048); t_commit();
    wr(KA, 32'hA357); wr(KB, 32'h67D2); t_commit();
    chk_ctrl("R11 keys valid", 32'h3);

    // R5 keys valid but still locked
    t_wr(0, 32'h12); t_commit();
    chk_field("R5 still locked", 0);

    // R7 interleaved write breaks the sequence
    wr(PROT, 32'h9136); t_commit();
    t_wr(1, 32'h44);
    wr(PROT, 32'h586A); t_commit();
    chk_ctrl("R7 interleaved write relocks", 32'h3);

    // R7 wrong first word
    wr(PROT, 32'h1234); t_commit();
    wr(PROT, 32'h586A); t_commit();
    chk_ctrl("R7 wrong word stays locked", 32'h3);

    // R6 proper sequence
    wr(PROT, 32'h9136); t_commit();
    wr(PROT, 32'h586A); t_commit();
    chk_ctrl("R6 unlocked", 32'h7);
    m_open = 1'b1;

    // R4 shadow invisible until commit, R12 invalid clears
    t_wr(0, 32'h2A);
    rd(field_addr(0), d); chk("R4 shadow not visible", d, 32'h0);
    t_commit();
    chk_field("R4 committed value", 0);
    chk_ctrl("R12 time valid after commit", 32'h6);
    chk("R12 time_valid port", {31'h0, time_valid}, 32'h1);

    // R2 apply timing
    t_wr(1, 32'h33);
    wr(COMMIT, 32'h1);
    for (int i = 0; i < 6; i++) begin
      chk("R2 apply timing", {31'h0, apply}, (i == CYC) ? 32'h1 : 32'h0);
      @(negedge clk);
    end
    for (int i = 0; i < 12; i++) m_act[i] = m_sh[i];
    chk_field("R2 field after apply", 1);
    chk("R2 time_out bus", {24'h0, time_out[15:8]}, 32'h33);

    // R2 busy bit duration
    wr(COMMIT, 32'h1);
    for (int i = 0; i < CYC + 1; i++) begin
      rd(CTRL, d);
      chk("R2 busy bit", {31'h0, d[6]}, (i < CYC) ? 32'h1 : 32'h0);
    end

    // R3 writes while busy ignored
    wr(COMMIT, 32'h1);
    wr(field_addr(2), 32'h55);
    wr(COMMIT, 32'h1);
    repeat (2) @(negedge clk);
    rd(CTRL, d);
    chk("R3 commit not restarted", {31'h0, d[6]}, 32'h0);
    t_commit();
    chk_field("R3 busy write dropped", 2);

    // R8 bad key byte
    wr(CTRL, 32'h0000_0010);
    chk_ctrl("R8 bad key clear ignored", 32'h6);
    t_wr(3, 32'h77);
    wr(CTRL, 32'h0000_0020);
    t_commit();
    chk_field("R8 bad key reload ignored", 3);

    // R9 reload discards pending
    t_wr(3, 32'h11);
    t_reload();
    t_commit();
    chk_field("R9 reload discards", 3);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int op, i;
      op = $urandom_range(0, 3);
      i  = $urandom_range(0, 11);
      case (op)
        0: t_wr(i, $urandom);
        1: t_commit();
        2: chk_field("R4 random read", i);
        default: t_reload();
      endcase
    end
    t_commit();
    for (int i = 0; i < 12; i++) chk_field("R4 final sweep", i);

    // R10 clear keys
    wr(CTRL, 32'h4310);
    chk_ctrl("R10 keys cleared", 32'h5);
    m_open = 1'b0;
    t_wr(0, 32'h01); t_commit();
    chk_field("R10 time write ignored", 0);
    chk_ctrl("R12 no time write keeps invalid", 32'h5);

    // R7 wrong word while unlocked
    wr(PROT, 32'h0000); t_commit();
    chk_ctrl("R7 relock when unlocked", 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule